// File: doc/BRIEF.md
# FIFO March Self-Test Sequencer

This block runs a memory march test on a FIFO. It has no address path into the FIFO's storage. It reaches every slot through the FIFO's own four primitives:

| Primitive | Action | Pointer |
|---|---|---|
| put | write at the write index | advances the write index |
| poke | write at the write index | leaves the index |
| peek | read at the read index | leaves the index |
| get | read at the read index | advances the read index |

Because of this, every march element walks the slots in ascending order only.

One element's operation list is replayed once per slot. Within each replay, the last write of the list advances the write index and the last read advances the read index. The next replay then lands on the next slot, and after as many replays as there are slots both indices have wrapped to where they started.

A test pattern P is captured when the test starts. Operations use either P or its bitwise complement. Each read result is compared with the value the program expects. The first mismatch stops the run and latches the element number and the slot count. A clean run ends with done high and fail low. The built-in program has five elements and is intended for a full-occupancy walk: it fills the FIFO, rewrites and checks each slot in place, and drains it at the end.

Top module: `march_fifo_bist`

## Requirements
- R1: After synchronous reset, busy, done and fail are 0, fail_elem and fail_slot are 0, and no FIFO request is raised.
- R2: A start pulse while busy is 0 captures pattern as P, clears done and fail, and raises busy on the next clock edge.
- R3: The program is applied element by element, and each element's list is replayed DEPTH times. Elements are numbered from 0, and "~P" below means the complement of P:
  - element 0: write P.
  - element 1: read P, write ~P, read ~P, write P, read P, write ~P.
  - element 2: read ~P, write P, write ~P.
  - element 3: read ~P, write P, write ~P, write P.
  - element 4: read P.
- R4: Within each replay, the last write of the element is issued as fifo_put and every earlier write as fifo_poke. fifo_wdata carries P, or its complement where the list says so.
- R5: Within each replay, the last read of the element is issued as fifo_get and every earlier read as fifo_peek. Each read result is compared with P, or its complement where the list says so.
- R6: At most one of fifo_put, fifo_poke, fifo_peek and fifo_get is high in any cycle. Each request lasts one cycle. fifo_rdata must show the addressed slot from the cycle after a peek or get request, and must hold it for one further cycle.
- R7: On the first read mismatch the run stops. fail and done go high and busy goes low. fail_elem latches the element number and fail_slot latches the replay count (0 to DEPTH-1). No further FIFO request is issued.
- R8: A run with no mismatch ends with done=1, fail=0 and busy=0. A write takes one cycle and a read takes three, so with the default program busy stays high for exactly 27*DEPTH cycles.
- R9: start is ignored while busy is high. The operation stream continues unchanged.
- R10: done, fail, fail_elem and fail_slot hold until the next accepted start. A start accepted after a finished or failed run clears them and runs the full program again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run when idle or finished |
| pattern | input | DW | Test pattern P, captured on an accepted start |
| fifo_put | output | 1 | Write and advance the write index |
| fifo_poke | output | 1 | Write without advancing |
| fifo_peek | output | 1 | Read without advancing |
| fifo_get | output | 1 | Read and advance the read index |
| fifo_wdata | output | DW | Write data for put and poke |
| fifo_rdata | input | DW | Read data returned by the FIFO |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, passed or failed |
| fail | output | 1 | A read mismatch was seen |
| fail_elem | output | EW | Element number of the first mismatch |
| fail_slot | output | SW | Replay count of the first mismatch |

## Verification
The operation program and the replay cursor fail in ways that show up almost at once at the request ports. A cursor that returns to the wrong list position, or a wrong last-of-kind decode, turns a put into a poke or a get into a peek within one replay of the faulty element. A mismatched count of advances makes the FIFO indices drift, so a healthy FIFO reports a false mismatch before the program ends. A fault in the comparator or in the latched failure fields shows up when a stuck bit is injected into one slot of the bench's FIFO model: the reported element and replay count disagree with the values worked out by hand. A fault in the phase control appears as a busy window whose length differs from 27*DEPTH cycles.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT,
    ST_CMP,
    ST_DONE
  } bist_state_t;

  // Operation word: bit 2 = write (1) / read (0),
  //                 bit 1 = complement pattern,
  //                 bit 0 = last operation of its element.
  localparam int OP_W      = 3;
  localparam int NUM_OPS   = 15;
  localparam int NUM_ELEMS = 5;

  localparam logic [OP_W-1:0] PROGRAM [NUM_OPS] = '{
    3'b101,                                         // element 0
    3'b000, 3'b110, 3'b010, 3'b100, 3'b000, 3'b111, // element 1
    3'b010, 3'b100, 3'b111,                         // element 2
    3'b010, 3'b100, 3'b110, 3'b101,                 // element 3
    3'b001                                          // element 4
  };

  // True when no later operation of the same kind exists in this element.
  function automatic logic final_of_kind(int idx);
    logic kind;
    logic res;
    logic stop;
    kind = PROGRAM[idx][2];
    res  = 1'b1;
    stop = PROGRAM[idx][0];
    for (int j = 0; j < NUM_OPS; j++) begin
      if (j > idx && !stop) begin
        if (PROGRAM[j][2] == kind) begin
          res  = 1'b0;
          stop = 1'b1;
        end else if (PROGRAM[j][0]) begin
          stop = 1'b1;
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/march_rom.sv
module march_rom
  import march_pkg::*;
#(
  parameter int PCW = 4
) (
  input  logic [PCW-1:0] pc,
  output logic           op_wr,
  output logic           op_cpl,
  output logic           op_eoe,
  output logic           op_fin
);

  logic [NUM_OPS-1:0] fin_tab;
  logic [NUM_OPS-1:0] wr_tab;
  logic [NUM_OPS-1:0] cpl_tab;
  logic [NUM_OPS-1:0] eoe_tab;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign fin_tab[g] = final_of_kind(g);
    assign wr_tab[g]  = PROGRAM[g][2];
    assign cpl_tab[g] = PROGRAM[g][1];
    assign eoe_tab[g] = PROGRAM[g][0];
  end

  always_comb begin
    op_wr  = 1'b0;
    op_cpl = 1'b0;
    op_eoe = 1'b1;
    op_fin = 1'b1;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (pc == PCW'(i)) begin
        op_wr  = wr_tab[i];
        op_cpl = cpl_tab[i];
        op_eoe = eoe_tab[i];
        op_fin = fin_tab[i];
      end
    end
  end

endmodule

// File: rtl/march_cursor.sv
module march_cursor
  import march_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SW    = 2,
  parameter int EW    = 3,
  parameter int PCW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           eoe,
  output logic [PCW-1:0] pc,
  output logic [SW-1:0]  slot,
  output logic [EW-1:0]  elem,
  output logic           at_end
);

  localparam logic [SW-1:0]  LAST_SLOT = SW'(DEPTH - 1);
  localparam logic [PCW-1:0] LAST_PC   = PCW'(NUM_OPS - 1);

  logic [PCW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc   <= '0;
      base <= '0;
      slot <= '0;
      elem <= '0;
    end else if (step) begin
      if (eoe) begin
        if (slot == LAST_SLOT) begin
          slot <= '0;
          pc   <= pc + 1'b1;
          base <= pc + 1'b1;
          elem <= elem + 1'b1;
        end else begin
          slot <= slot + 1'b1;
          pc   <= base;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  assign at_end = eoe && (slot == LAST_SLOT) && (pc == LAST_PC);

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] exp_in,
  input  logic [DW-1:0] rdata,
  output logic          mismatch
);

  logic [DW-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst)       exp_q <= '0;
    else if (load) exp_q <= exp_in;
  end

  assign mismatch = (rdata != exp_q);

endmodule

// File: rtl/march_fifo_bist.sv
module march_fifo_bist
  import march_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int DEPTH = 4,
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW    = $clog2(NUM_ELEMS),
  localparam int PCW   = $clog2(NUM_OPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] pattern,
  output logic          fifo_put,
  output logic          fifo_poke,
  output logic          fifo_peek,
  output logic          fifo_get,
  output logic [DW-1:0] fifo_wdata,
  input  logic [DW-1:0] fifo_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [EW-1:0] fail_elem,
  output logic [SW-1:0] fail_slot
);

  bist_state_t    state;
  logic [DW-1:0]  pat_q;
  logic [PCW-1:0] pc;
  logic [SW-1:0]  slot;
  logic [EW-1:0]  elem;
  logic           at_end;
  logic           op_wr, op_cpl, op_eoe, op_fin;
  logic           mismatch;
  logic           clr, step, load_exp;
  logic [DW-1:0]  op_data;

  assign clr      = (state == ST_IDLE || state == ST_DONE) && start;
  assign step     = (state == ST_RUN && op_wr) || (state == ST_CMP && !mismatch);
  assign load_exp = (state == ST_RUN) && !op_wr;
  assign op_data  = op_cpl ? ~pat_q : pat_q;

  march_rom #(.PCW(PCW)) u_rom (
    .pc     (pc),
    .op_wr  (op_wr),
    .op_cpl (op_cpl),
    .op_eoe (op_eoe),
    .op_fin (op_fin)
  );

  march_cursor #(.DEPTH(DEPTH), .SW(SW), .EW(EW), .PCW(PCW)) u_cursor (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .step   (step),
    .eoe    (op_eoe),
    .pc     (pc),
    .slot   (slot),
    .elem   (elem),
    .at_end (at_end)
  );

  march_cmp #(.DW(DW)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .load     (load_exp),
    .exp_in   (op_data),
    .rdata    (fifo_rdata),
    .mismatch (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pat_q      <= '0;
      fifo_put   <= 1'b0;
      fifo_poke  <= 1'b0;
      fifo_peek  <= 1'b0;
      fifo_get   <= 1'b0;
      fifo_wdata <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_elem  <= '0;
      fail_slot  <= '0;
    end else begin
      fifo_put  <= 1'b0;
      fifo_poke <= 1'b0;
      fifo_peek <= 1'b0;
      fifo_get  <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            pat_q     <= pattern;
            busy      <= 1'b1;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_elem <= '0;
            fail_slot <= '0;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (op_wr) begin
            fifo_put   <= op_fin;
            fifo_poke  <= !op_fin;
            fifo_wdata <= op_data;
            if (at_end) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= ST_DONE;
            end
          end else begin
            fifo_peek <= !op_fin;
            fifo_get  <= op_fin;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: state <= ST_CMP;
        ST_CMP: begin
          if (mismatch) begin
            fail      <= 1'b1;
            fail_elem <= elem;
            fail_slot <= slot;
            busy      <= 1'b0;
            done      <= 1'b1;
            state     <= ST_DONE;
          end else if (at_end) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/march_fifo_bist_chk.sv
module march_fifo_bist_chk #(
  parameter int EW = 3,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          fifo_put,
  input logic          fifo_poke,
  input logic          fifo_peek,
  input logic          fifo_get,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [EW-1:0] fail_elem,
  input logic [SW-1:0] fail_slot
);

  logic any_req;
  assign any_req = fifo_put | fifo_poke | fifo_peek | fifo_get;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_put, fifo_poke, fifo_peek, fifo_get})); // R6

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  AST_FAIL_MEANS_DONE: assert property (@(posedge clk) disable iff (rst)
    fail |-> (done && !busy)); // R7

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !any_req); // R7

  AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(done && busy)); // R8

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_elem) && $stable(fail_slot))); // R10

endmodule

bind march_fifo_bist march_fifo_bist_chk #(.EW(EW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .fifo_put  (fifo_put),
  .fifo_poke (fifo_poke),
  .fifo_peek (fifo_peek),
  .fifo_get  (fifo_get),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_elem (fail_elem),
  .fail_slot (fail_slot)
);

// File: tb/march_fifo_bist_test.sv
module march_fifo_bist_test;

  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int SW    = 2;
  localparam int EW    = 3;
  localparam int NOPS  = 15;

  // request kinds seen by the scoreboard
  localparam int K_PUT  = 0;
  localparam int K_POKE = 1;
  localparam int K_PEEK = 2;
  localparam int K_GET  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] pattern = '0;
  logic          fifo_put, fifo_poke, fifo_peek, fifo_get;
  logic [DW-1:0] fifo_wdata;
  logic [DW-1:0] fifo_rdata;
  logic          busy, done, fail;
  logic [EW-1:0] fail_elem;
  logic [SW-1:0] fail_slot;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  march_fifo_bist #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .start(start), .pattern(pattern),
    .fifo_put(fifo_put), .fifo_poke(fifo_poke), .fifo_peek(fifo_peek), .fifo_get(fifo_get),
    .fifo_wdata(fifo_wdata), .fifo_rdata(fifo_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_elem(fail_elem), .fail_slot(fail_slot)
  );

  // ---------------- FIFO model with fault injection ----------------
  logic [DW-1:0] mem [DEPTH];
  int            wi = 0;
  int            ri = 0;
  logic [DW-1:0] rd_q = '0;
  logic          fifo_clr = 1'b0;
  logic          flt_en = 1'b0;
  int            flt_slot = 0;
  logic [DW-1:0] flt_or = '0;
  logic [DW-1:0] flt_and = '1;

  assign fifo_rdata = rd_q;

  always @(posedge clk) begin
    if (fifo_clr) begin
      wi <= 0;
      ri <= 0;
    end else begin
      if (fifo_put || fifo_poke)
        mem[wi] <= (flt_en && wi == flt_slot) ? ((fifo_wdata | flt_or) & flt_and) : fifo_wdata;
      if (fifo_put) wi <= (wi + 1) % DEPTH;
      if (fifo_peek || fifo_get) rd_q <= mem[ri];
      if (fifo_get) ri <= (ri + 1) % DEPTH;
    end
  end

  // ---------------- reference program (from R3) ----------------
  bit ref_wr  [NOPS] = '{1, 0,1,0,1,0,1, 0,1,1, 0,1,1,1, 0};
  bit ref_inv [NOPS] = '{0, 0,1,1,0,0,1, 1,0,1, 1,0,1,0, 0};
  bit ref_end [NOPS] = '{1, 0,0,0,0,0,1, 0,0,1, 0,0,0,1, 1};

  typedef struct {
    int            kind;
    logic [DW-1:0] data;
  } item_t;

  item_t sbq[$];
  logic  sb_en = 1'b0;
  int    stray_reqs = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: push the expected request stream for one full run
  task automatic push_expected(input logic [DW-1:0] p);
    int first = 0;
    while (first < NOPS) begin
      int last = first;
      while (!ref_end[last]) last++;
      for (int s = 0; s < DEPTH; s++) begin
        for (int i = first; i <= last; i++) begin
          item_t it;
          bit later = 1'b0;
          for (int j = i + 1; j <= last; j++)
            if (ref_wr[j] == ref_wr[i]) later = 1'b1;
          if (ref_wr[i]) it.kind = later ? K_POKE : K_PUT;
          else           it.kind = later ? K_PEEK : K_GET;
          it.data = ref_inv[i] ? ~p : p;
          sbq.push_back(it);
        end
      end
      first = last + 1;
    end
  endtask

  // monitor: pop and compare every request the design issues
  always @(negedge clk) begin
    if (!rst && (fifo_put || fifo_poke || fifo_peek || fifo_get)) begin
      if (!sb_en) begin
        stray_reqs++;
      end else begin
        int    got;
        item_t e;
        check($countones({fifo_put, fifo_poke, fifo_peek, fifo_get}) == 1, "R6",
              "one request per cycle",
              $countones({fifo_put, fifo_poke, fifo_peek, fifo_get}), 1);
        got = fifo_put ? K_PUT : fifo_poke ? K_POKE : fifo_peek ? K_PEEK : K_GET;
        if (sbq.size() == 0) begin
          check(1'b0, "R3", "request beyond program end", got, -1);
        end else begin
          e = sbq.pop_front();
          if (e.kind == K_PUT || e.kind == K_POKE) begin
            check(got == e.kind, "R4", "write kind", got, e.kind);
            check(fifo_wdata == e.data, "R4", "write data", fifo_wdata, e.data);
          end else begin
            check(got == e.kind, "R5", "read kind", got, e.kind);
          end
        end
      end
    end
  end

  // run one test; optionally pulse start again at busy cycle 20
  task automatic run(input logic [DW-1:0] p, input bit extra_start, output int bcycles);
    int n = 0;
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    pattern  = p;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0 && fail == 1'b0, "R2", "busy after start",
          {busy, done, fail}, 3'b100);
    while (busy && n < 5000) begin
      n++;
      start = (extra_start && n == 20);
      @(negedge clk);
    end
    start   = 1'b0;
    bcycles = n;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, done, fail} == 3'b000, "R1", "status in reset", {busy, done, fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, fail, fail_elem, fail_slot} == '0, "R1", "status after reset",
          {busy, done, fail, fail_elem, fail_slot}, 0);
    check({fifo_put, fifo_poke, fifo_peek, fifo_get} == 4'b0, "R1", "no request after reset",
          {fifo_put, fifo_poke, fifo_peek, fifo_get}, 0);

    // Clean run with a stray start mid-way (R8, R9)
    sb_en = 1'b1;
    push_expected(8'hA5);
    run(8'hA5, 1'b1, bc);
    check(bc == 27 * DEPTH, "R8", "busy cycles", bc, 27 * DEPTH);
    check(done && !fail, "R8", "pass result", {done, fail}, 2'b10);
    check(sbq.size() == 0, "R9", "stream unchanged by extra start", sbq.size(), 0);
    repeat (6) @(negedge clk);
    check(done && !busy && !fail, "R10", "done holds while idle", {done, busy, fail}, 3'b100);

    // Second clean run from the done state with another pattern (R3, R10)
    push_expected(8'h3C);
    run(8'h3C, 1'b0, bc);
    check(sbq.size() == 0, "R3", "whole program issued", sbq.size(), 0);
    check(done && !fail && bc == 27 * DEPTH, "R10", "rerun from done", bc, 27 * DEPTH);

    // Fault: slot 2 bit 0 stuck at 1, P = 00 -> element 1, replay 2 (R7)
    sb_en = 1'b0;
    sbq.delete();
    flt_en = 1'b1; flt_slot = 2; flt_or = 8'h01; flt_and = 8'hFF;
    run(8'h00, 1'b0, bc);
    check(fail == 1'b1 && done == 1'b1 && busy == 1'b0, "R7", "stuck-at-1 flagged",
          {fail, done, busy}, 3'b110);
    check(fail_elem == 3'd1, "R7", "failing element", fail_elem, 1);
    check(fail_slot == 2'd2, "R7", "failing replay", fail_slot, 2);
    stray_reqs = 0;
    repeat (8) @(negedge clk);
    check(stray_reqs == 0, "R7", "no request after stop", stray_reqs, 0);
    check(fail && fail_elem == 3'd1 && fail_slot == 2'd2, "R10", "failure fields hold",
          {fail, fail_elem, fail_slot}, {1'b1, 3'd1, 2'd2});

    // Fault: slot 3 bit 7 stuck at 0, P = 0F -> element 1, replay 3 (R7)
    flt_slot = 3; flt_or = 8'h00; flt_and = 8'h7F;
    run(8'h0F, 1'b0, bc);
    check(fail && fail_elem == 3'd1 && fail_slot == 2'd3, "R7", "stuck-at-0 flagged",
          {fail, fail_elem, fail_slot}, {1'b1, 3'd1, 2'd3});

    // Restart after a failure with a healthy FIFO (R10, R5)
    flt_en = 1'b0;
    sb_en  = 1'b1;
    push_expected(8'h5A);
    run(8'h5A, 1'b0, bc);
    check(!fail && done && fail_elem == 0 && fail_slot == 0, "R10", "restart clears failure",
          {fail, done, fail_elem, fail_slot}, {1'b0, 1'b1, 3'd0, 2'd0});
    check(sbq.size() == 0 && bc == 27 * DEPTH, "R5", "reads compared clean", bc, 27 * DEPTH);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule